// File: doc/BRIEF.md
# Serial Flash Clock Divider with Capture Shift

This block derives the serial clock for an external flash device from the kernel clock. A programmable ratio sets the serial clock period in whole kernel cycles. Alongside the clock it produces two one-cycle strobes for the serial shifter. The launch strobe marks the kernel cycles in which output bits must change. The capture strobe marks the cycles in which input bits must be sampled.

Both strobes follow one of two edge schemes. In single-rate mode outputs move on falling clock edges, and input capture happens on the following rising edge or, with the shift option set, one half period later. In double-rate mode bits move on both edges, and each one is captured on the opposite edge that follows. The surrounding sequencer raises a run enable while a transfer needs clocks. The clock starts and stops only on whole-period boundaries, so no runt pulse reaches the pin.

Top module: `sck_divider`

## Requirements
- R1: For `ratio_m1` = M in 1..255, the serial clock period is M+1 kernel cycles. The value of `ratio_m1` is taken in the cycle the run starts.
- R2: With N = M+1 and M ≥ 1, each period starts with ceil(N/2) kernel cycles high and ends with floor(N/2) cycles low, so an odd ratio gives the longer high phase.
- R3: With `ratio_m1` = 0, `sck` is the kernel clock gated: high during the first half of every running kernel cycle and low in the second half.
- R4: `sck` is low and both strobes are 0 in reset and while no run is active. When `run_en` is seen high at a clock edge, `sck` rises in the cycle that follows. When `run_en` falls, the current period completes in full and the clock then rests low.
- R5: In single-rate mode (`ddr_mode` = 0), `launch` is 1 for exactly the kernel cycle that follows each falling `sck` edge and is 0 at every other time.
- R6: In single-rate mode with `smp_delay` = 0, `capture` is 1 in the cycle after each rising `sck` edge that has a falling edge earlier in the same run. It is therefore 0 on the first rising edge of a run.
- R7: In single-rate mode with `smp_delay` = 1, `capture` is 1 in the cycle after each falling `sck` edge except the first falling edge of the run.
- R8: In double-rate mode (`ddr_mode` = 1), `launch` is 1 after every `sck` edge. `capture` is 1 after every edge except the first edge of the run. `smp_delay` has no effect in this mode.
- R9: A change of `ratio_m1` during a run has no effect on the period until the next run starts.
- R10: With `ratio_m1` = 0, `launch` is 1 in every running cycle. `capture` is 1 in every running cycle in double-rate mode, and in every running cycle but the first in single-rate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ratio_m1 | input | 8 | Division ratio minus one; 0 selects bypass |
| ddr_mode | input | 1 | 1 selects the double-rate edge scheme |
| smp_delay | input | 1 | 1 moves single-rate capture half a period later |
| run_en | input | 1 | Clock run request from the sequencer |
| sck | output | 1 | Serial clock to the flash device |
| launch | output | 1 | One-cycle strobe: change output bits now |
| capture | output | 1 | One-cycle strobe: sample input bits now |

## Verification
The checker watches, on every cycle, that the clock rests low with silent strobes while idle, that a run ends only at a period boundary, and that the phase counter stays within the ratio. It also checks that single-rate launches coincide with falling edges, that unshifted captures coincide with rising edges, and that every double-rate edge carries a launch. Exact period lengths, the high and low phase split for odd ratios, the first-edge suppression of capture and the gated bypass waveform can only be shown by the bench's directed runs. The same holds for the completion of a period after the enable drops and for the immunity to ratio changes mid-run.

// File: rtl/sck_divider.sv
module sck_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] ratio_m1,
  input  logic             ddr_mode,
  input  logic             smp_delay,
  input  logic             run_en,
  output logic             sck,
  output logic             launch,
  output logic             capture
);

  logic             run_q, run_n;
  logic [DIV_W-1:0] div_q, div_n, cnt_q, cnt_n;
  logic [DIV_W:0]   hi_n;
  logic             sck_q, sck_n, armed_q, armed_n, armed_now, gate_q;
  logic             rise_n, fall_n, launch_n, capture_n;
  logic             start, period_end, byp_q;

  assign start      = !run_q && run_en;
  assign period_end = run_q && (cnt_q == div_q);
  assign byp_q      = (div_q == '0);

  always_comb begin
    run_n  = run_q;
    div_n  = div_q;
    cnt_n  = cnt_q;
    rise_n = 1'b0;
    fall_n = 1'b0;
    hi_n   = '0;
    if (start) begin
      run_n  = 1'b1;
      div_n  = ratio_m1;
      cnt_n  = '0;
      rise_n = 1'b1;
    end else if (period_end) begin
      cnt_n = '0;
      if (run_en) rise_n = 1'b1;
      else        run_n  = 1'b0;
    end else if (run_q) begin
      cnt_n = cnt_q + DIV_W'(1);
    end
    hi_n = ({1'b0, div_n} + (DIV_W+1)'(2)) >> 1;
    if (div_n == '0) fall_n = rise_n;
    else if (run_q && !start && !period_end) fall_n = ({1'b0, cnt_n} == hi_n);
    sck_n     = run_n && (div_n != '0) && ({1'b0, cnt_n} < hi_n);
    armed_now = start ? 1'b0 : armed_q;
    armed_n   = run_n && (armed_now || fall_n);
    launch_n  = fall_n || (ddr_mode && rise_n);
    if (ddr_mode)       capture_n = fall_n || (rise_n && armed_now);
    else if (smp_delay) capture_n = fall_n && armed_now;
    else                capture_n = rise_n && armed_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      div_q   <= '0;
      cnt_q   <= '0;
      sck_q   <= 1'b0;
      armed_q <= 1'b0;
      launch  <= 1'b0;
      capture <= 1'b0;
    end else begin
      run_q   <= run_n;
      div_q   <= div_n;
      cnt_q   <= cnt_n;
      sck_q   <= sck_n;
      armed_q <= armed_n;
      launch  <= launch_n;
      capture <= capture_n;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= run_n && (div_n == '0);
  end

  assign sck = byp_q ? (clk && gate_q) : sck_q;

endmodule

// File: rtl/sck_divider_chk.sv
module sck_divider_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ddr_mode,
  input logic             smp_delay,
  input logic             run_q,
  input logic             sck_q,
  input logic [DIV_W-1:0] cnt_q,
  input logic [DIV_W-1:0] div_q,
  input logic             launch,
  input logic             capture
);

  a_r4_rest_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (!sck_q && !launch && !capture));

  a_r4_stop_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> ($past(cnt_q) == $past(div_q)));

  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q <= div_q));

  a_r3_bypass_reg_low: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && div_q == '0) |-> !sck_q);

  a_r5_launch_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !$past(ddr_mode) && div_q != '0) |-> (!sck_q && $past(sck_q)));

  a_r6_capture_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !$past(ddr_mode) && !$past(smp_delay) && div_q != '0) |-> $rose(sck_q));

  a_r8_launch_each_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ddr_mode) && run_q && div_q != '0 && sck_q != $past(sck_q)) |-> launch);

endmodule

bind sck_divider sck_divider_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ddr_mode(ddr_mode), .smp_delay(smp_delay),
  .run_q(run_q), .sck_q(sck_q), .cnt_q(cnt_q), .div_q(div_q),
  .launch(launch), .capture(capture)
);

// File: tb/sck_divider_test.sv
module sck_divider_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ratio_m1 = 8'd0;
  logic       ddr_mode = 1'b0, smp_delay = 1'b0, run_en = 1'b0;
  logic       sck, launch, capture;
  int         total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  sck_divider uut (
    .clk(clk), .rst_n(rst_n), .ratio_m1(ratio_m1), .ddr_mode(ddr_mode),
    .smp_delay(smp_delay), .run_en(run_en),
    .sck(sck), .launch(launch), .capture(capture)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic go_idle();
    @(posedge clk); #1 run_en = 1'b0;
    repeat (300) @(posedge clk);
  endtask

  // drop_j / chg_j: cycle in which run_en drops / ratio changes (0 = never)
  task automatic run_div(input int m, input logic ddr, input logic sh, input int cycles,
                         input int drop_j, input int chg_j,
                         input string rs, input string rl, input string rc);
    int n, h, ph, end_j;
    logic rise, fall, es, el, ec;
    n = m + 1;
    h = (n + 1) / 2;
    end_j = (drop_j > 0) ? (((drop_j - 1) / n) + 1) * n : cycles + 1;
    @(posedge clk); #1;
    ratio_m1 = 8'(m); ddr_mode = ddr; smp_delay = sh; run_en = 1'b1;
    for (int j = 1; j <= cycles; j++) begin
      @(posedge clk);
      #1;
      if (j == drop_j) run_en = 1'b0;
      if (j == chg_j) ratio_m1 = ratio_m1 ^ 8'h5A;
      #1;
      ph   = (j - 1) % n;
      rise = (ph == 0);
      fall = (ph == h);
      es   = (ph < h);
      el   = fall || (ddr && rise);
      if (ddr)     ec = fall || (rise && j > 1);
      else if (sh) ec = fall && (j - 1 >= n);
      else         ec = rise && (j - 1 >= n);
      if (j > end_j) begin es = 0; el = 0; ec = 0; end
      chk(rs, "sck", sck, es);
      chk(rl, "launch", launch, el);
      chk(rc, "capture", capture, ec);
    end
    go_idle();
  endtask

  task automatic run_byp(input logic ddr, input logic sh, input int cycles);
    @(posedge clk); #1;
    ratio_m1 = 8'd0; ddr_mode = ddr; smp_delay = sh; run_en = 1'b1;
    for (int j = 1; j <= cycles; j++) begin
      @(posedge clk); #2;
      chk("R3", "sck high half", sck, 1'b1);
      chk("R10", "launch", launch, 1'b1);
      chk("R10", "capture", capture, ddr ? 1'b1 : (j >= 2));
      @(negedge clk); #2;
      chk("R3", "sck low half", sck, 1'b0);
    end
    @(posedge clk); #1 run_en = 1'b0;
    #1 chk("R4", "bypass last pulse", sck, 1'b1);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #2;
      chk("R4", "bypass stopped sck", sck, 1'b0);
      chk("R4", "bypass stopped launch", launch, 1'b0);
      chk("R4", "bypass stopped capture", capture, 1'b0);
    end
    go_idle();
  endtask

  task automatic test_reset();
    run_en = 1'b1;
    repeat (3) begin
      @(posedge clk); #2;
      chk("R4", "reset sck", sck, 1'b0);
      chk("R4", "reset launch", launch, 1'b0);
      chk("R4", "reset capture", capture, 1'b0);
    end
    run_en = 1'b0;
    rst_n = 1'b1;
    repeat (5) begin
      @(posedge clk); #2;
      chk("R4", "idle sck", sck, 1'b0);
      chk("R4", "idle launch", launch, 1'b0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    test_reset();
    run_div(1,   1'b0, 1'b0, 12,  0, 0, "R1", "R5", "R6");
    run_div(4,   1'b0, 1'b0, 20,  0, 0, "R2", "R5", "R6");
    run_div(6,   1'b0, 1'b0, 21,  0, 0, "R2", "R5", "R6");
    run_div(2,   1'b0, 1'b1, 15,  0, 0, "R1", "R5", "R7");
    run_div(3,   1'b1, 1'b0, 16,  0, 0, "R1", "R8", "R8");
    run_div(4,   1'b1, 1'b1, 15,  0, 0, "R2", "R8", "R8");
    run_div(255, 1'b0, 1'b0, 520, 0, 0, "R1", "R5", "R6");
    run_div(3,   1'b0, 1'b0, 16,  6, 0, "R4", "R4", "R4");
    run_div(2,   1'b0, 1'b0, 15,  0, 4, "R9", "R9", "R9");
    run_byp(1'b0, 1'b0, 6);
    run_byp(1'b0, 1'b1, 6);
    run_byp(1'b1, 1'b0, 6);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule